// File: doc/BRIEF.md
# Mean-of-k Computation Unit

This unit keeps a small array of unsigned words and, on request, reports the integer mean of the first k of them. While the unit is idle, software writes words into the array through a simple address/data/write-enable port. The caller then places k-1 on a count input and raises `start_i`. A controller walks an index down from k-1 to 0 and adds one stored word to a cleared running sum on each cycle. It then hands the sum to a bit-serial restoring divider whose divisor is k.

When the divider finishes, the unit raises `done_o` and shows the quotient and the remainder. Both hold steady until the caller lowers `start_i`. The running sum is wide enough that k full-scale words cannot overflow. Writes that arrive while a computation is under way are dropped, so the data cannot change in the middle of a run.

Top module: `mean_unit`

## Requirements
- R1: After reset, `done_o` is 0, `mean_o` is 0 and `rem_o` is 0.
- R2: A write made while idle stores `wr_data_i` at `wr_addr_i`. A run with `last_idx_i` = k-1 uses exactly the words at addresses 0 to k-1.
- R3: When `done_o` is 1, `mean_o` equals the floor of (sum of the k words) divided by k.
- R4: When `done_o` is 1, `rem_o` equals (sum of the k words) modulo k. It is always less than k.
- R5: With every word at full scale (2^DATA_W-1) and k = 2^ADDR_W, the sum does not overflow. The result is the full-scale value with remainder 0.
- R6: A write issued while a run is in progress has no effect on the stored array. It also has no effect on the current result.
- R7: `done_o` rises on the (k + DATA_W + ADDR_W + 2)-th rising clock edge after the edge that first samples `start_i` high in the idle state.
- R8: While `start_i` stays high after completion, `done_o` stays 1 and `mean_o` and `rem_o` do not change. One edge after `start_i` is seen low, `done_o` is 0 and the unit is idle.
- R9: `last_idx_i` is captured when the run starts. Changing it during a run does not alter that run's result.
- R10: With k = 1, `mean_o` equals the word at address 0 and `rem_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Array write enable, honoured only while idle |
| wr_addr_i | input | ADDR_W | Array write address |
| wr_data_i | input | DATA_W | Array write data |
| start_i | input | 1 | Starts a run; must stay high until `done_o` is seen |
| last_idx_i | input | ADDR_W | k-1, the highest address included in the mean |
| done_o | output | 1 | Result valid |
| mean_o | output | DATA_W+ADDR_W | Quotient of sum by k |
| rem_o | output | ADDR_W+1 | Remainder of sum by k |

## Verification
On every cycle, the in-line properties check several things. A start seen in idle always leaves idle. The completion state is held while start is high, and done falls only after start has been low. The index steps down by one per accumulation cycle, and the running sum never decreases. The divider's partial remainder stays below its divisor. A blocked write leaves the addressed word untouched. The arithmetic result, the exact latency for each k, and the effect of a write or a count change made in the middle of a run can only be shown by the bench scenarios. Those scenarios compare outputs against reference sums over random and full-scale data.

// File: rtl/mean_pkg.sv
package mean_pkg;

  // Controller states; the order is also the order a run passes through them.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ACC   = 3'd1,
    ST_DLOAD = 3'd2,
    ST_DIV   = 3'd3,
    ST_DONE  = 3'd4
  } mean_state_e;

endpackage

// File: rtl/mean_store.sv
module mean_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_allow_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  wsel;

  // Address decoder: one word-select line per entry, gated by the permit.
  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign wsel[g] = wr_en_i && wr_allow_i && (wr_addr_i == ADDR_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < DEPTH; w++) begin
      if (wsel[w]) mem[w] <= wr_data_i;
    end
  end

  assign rd_data_o = mem[rd_addr_i];

  // R6
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_allow_i) |=> (mem[$past(wr_addr_i)] == $past(mem[wr_addr_i])));

endmodule

// File: rtl/mean_ctrl.sv
module mean_ctrl
  import mean_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        idx_zero_i,
  input  logic        div_last_i,
  output mean_state_e state_o,
  output logic        done_o
);

  mean_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i)    state_d = ST_ACC;
      ST_ACC:   if (idx_zero_i) state_d = ST_DLOAD;
      ST_DLOAD:                 state_d = ST_DIV;
      ST_DIV:   if (div_last_i) state_d = ST_DONE;
      ST_DONE:  if (!start_i)   state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
  assign done_o  = (state_q == ST_DONE);

  // R7
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i) |=> (state_q == ST_ACC));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && start_i) |=> (state_q == ST_DONE));

  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_o) |-> !$past(start_i));

endmodule

// File: rtl/mean_divider.sv
module mean_divider #(
  parameter int NUM_W = 11,
  parameter int DEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             last_o,
  output logic [NUM_W-1:0] quot_o,
  output logic [DEN_W-1:0] rem_o
);

  localparam int CNT_W = (NUM_W > 1) ? $clog2(NUM_W) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(NUM_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [DEN_W+1:0] SUB_ONE = (DEN_W + 2)'(1);

  logic [NUM_W-1:0] quot_q, quot_d;
  logic [DEN_W-1:0] rem_q, rem_d;
  logic [DEN_W-1:0] den_q, den_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic [DEN_W:0]   shifted;
  logic [DEN_W+1:0] trial;
  logic             no_borrow;

  // Shift remainder:dividend left one place, then try subtracting the divisor.
  // The carry out of shifted + ~den + 1 is 1 exactly when no borrow occurs.
  assign shifted   = {rem_q, quot_q[NUM_W-1]};
  assign trial     = {1'b0, shifted} + {1'b0, ~{1'b0, den_q}} + SUB_ONE;
  assign no_borrow = trial[DEN_W+1];

  always_comb begin
    quot_d = quot_q;
    rem_d  = rem_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    if (load_i) begin
      quot_d = num_i;
      rem_d  = '0;
      den_d  = den_i;
      cnt_d  = CNT_TOP;
    end else if (step_i) begin
      quot_d = {quot_q[NUM_W-2:0], no_borrow};
      rem_d  = no_borrow ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
      if (cnt_q != '0) cnt_d = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quot_q <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
    end else if (load_i || step_i) begin
      quot_q <= quot_d;
      rem_q  <= rem_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
    end
  end

  assign last_o = (cnt_q == '0);
  assign quot_o = quot_q;
  assign rem_o  = rem_q;

  // R4
  rem_below_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (den_q != '0) |-> (rem_q < den_q));

endmodule

// File: rtl/mean_unit.sv
module mean_unit
  import mean_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     start_i,
  input  logic [ADDR_W-1:0]        last_idx_i,
  output logic                     done_o,
  output logic [DATA_W+ADDR_W-1:0] mean_o,
  output logic [ADDR_W:0]          rem_o
);

  localparam int ACC_W = DATA_W + ADDR_W;
  localparam int DEN_W = ADDR_W + 1;
  localparam logic [ADDR_W-1:0] IDX_ONE = ADDR_W'(1);
  localparam logic [DEN_W-1:0]  DEN_ONE = DEN_W'(1);

  // Reset: asserted at once, released after two clean edges.
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  mean_state_e       state;
  logic              idx_zero, div_last;
  logic [ADDR_W-1:0] idx_q, idx_d, last_q, last_d;
  logic [ACC_W-1:0]  sum_q, sum_d;
  logic [DATA_W-1:0] rd_data;
  logic              is_idle, is_acc;

  assign is_idle  = (state == ST_IDLE);
  assign is_acc   = (state == ST_ACC);
  assign idx_zero = (idx_q == '0);

  mean_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .idx_zero_i (idx_zero),
    .div_last_i (div_last),
    .state_o    (state),
    .done_o     (done_o)
  );

  mean_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_allow_i (is_idle),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (idx_q),
    .rd_data_o  (rd_data)
  );

  // Index, captured count and running sum.
  always_comb begin
    idx_d  = idx_q;
    last_d = last_q;
    sum_d  = sum_q;
    if (is_idle) begin
      idx_d  = last_idx_i;
      last_d = last_idx_i;
      sum_d  = '0;
    end else if (is_acc) begin
      sum_d = sum_q + {{ADDR_W{1'b0}}, rd_data};
      if (!idx_zero) idx_d = idx_q - IDX_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      idx_q  <= '0;
      last_q <= '0;
      sum_q  <= '0;
    end else if (is_idle || is_acc) begin
      idx_q  <= idx_d;
      last_q <= last_d;
      sum_q  <= sum_d;
    end
  end

  logic [DEN_W-1:0] divisor;
  assign divisor = {1'b0, last_q} + DEN_ONE;

  mean_divider #(.NUM_W(ACC_W), .DEN_W(DEN_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (state == ST_DLOAD),
    .step_i (state == ST_DIV),
    .num_i  (sum_q),
    .den_i  (divisor),
    .last_o (div_last),
    .quot_o (mean_o),
    .rem_o  (rem_o)
  );

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (is_acc && !idx_zero) |=> (idx_q == $past(idx_q) - IDX_ONE));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_acc |=> (sum_q >= $past(sum_q)));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && $past(done_o)) |-> ($stable(mean_o) && $stable(rem_o)));

endmodule

// File: tb/sim_mean_unit.sv
module sim_mean_unit;

  localparam int DW    = 8;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;
  localparam int ACCW  = DW + AW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   wr_addr = '0;
  logic [DW-1:0]   wr_data = '0;
  logic            start = 1'b0;
  logic [AW-1:0]   last_idx = '0;
  logic            done;
  logic [ACCW-1:0] mean;
  logic [AW:0]     rem;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;
  int ref_mem [DEPTH];

  always #5 clk = ~clk;

  mean_unit #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .start_i(start), .last_idx_i(last_idx),
    .done_o(done), .mean_o(mean), .rem_o(rem)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_sum(input int k);
    int s = 0;
    for (int i = 0; i < k; i++) s += ref_mem[i];
    return s;
  endfunction

  task automatic write_word(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    ref_mem[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Runs one computation. busy_wr: write a different word to address 0
  // mid-run. alt_k: change last_idx mid-run. hold: extra cycles start stays high.
  task automatic run_mean(input int k, input bit busy_wr, input bit alt_k,
                          input int hold, input string req);
    int n = 0;
    bit got = 1'b0;
    int s = ref_sum(k);
    longint held_m;
    longint held_r;
    @(negedge clk);
    last_idx = AW'(k - 1);
    start = 1'b1;
    while (!got && n < 300) begin
      @(posedge clk); #1;
      n++;
      if (n == 2) begin
        if (busy_wr) begin
          wr_en = 1'b1; wr_addr = '0; wr_data = DW'(~ref_mem[0]);
        end
        if (alt_k) last_idx = AW'(DEPTH - k);
      end
      if (n == 3) wr_en = 1'b0;
      got = done;
    end
    // R7 latency k + DATA_W + ADDR_W + 2 edges
    check(n == k + ACCW + 2, "R7 latency", n, k + ACCW + 2);
    // R3 quotient, R4 remainder
    check(mean == ACCW'(s / k), {req, " R3 mean"}, mean, s / k);
    check(rem == (AW+1)'(s % k), {req, " R4 rem"}, rem, s % k);
    held_m = mean;
    held_r = rem;
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); #1;
      // R8 done and results held while start high
      check(done && mean == held_m && rem == held_r, "R8 hold", done, 1);
    end
    @(negedge clk);
    start = 1'b0;
    @(posedge clk); #1;
    // R8 done drops one edge after start low
    check(!done, "R8 release", done, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(!done, "R1 done", done, 0);
    check(mean == 0, "R1 mean", mean, 0);
    check(rem == 0, "R1 rem", rem, 0);

    // R10 single word
    write_word(0, 200);
    run_mean(1, 1'b0, 1'b0, 1, "R10");

    // R5 full scale over the whole array
    for (int a = 0; a < DEPTH; a++) write_word(a, (1 << DW) - 1);
    run_mean(DEPTH, 1'b0, 1'b0, 2, "R5");
    check(mean == (1 << DW) - 1, "R5 full", mean, (1 << DW) - 1);

    // R2 random data for several k
    for (int t = 0; t < 8; t++) begin
      for (int a = 0; a < DEPTH; a++) write_word(a, int'($urandom_range(0, (1 << DW) - 1)));
      run_mean(int'($urandom_range(1, DEPTH)), 1'b0, 1'b0, 1, "R2");
    end

    // R2 only addresses below k count: large value beyond k
    for (int a = 0; a < DEPTH; a++) write_word(a, a + 1);
    write_word(DEPTH - 1, 255);
    run_mean(3, 1'b0, 1'b0, 0, "R2 window");

    // R6 write during a run ignored, then rerun shows array untouched
    write_word(0, 17);
    run_mean(5, 1'b1, 1'b0, 0, "R6 busy");
    run_mean(5, 1'b0, 1'b0, 0, "R6 after");

    // R9 count change mid-run ignored
    run_mean(2, 1'b0, 1'b1, 0, "R9");
    run_mean(7, 1'b0, 1'b1, 3, "R9");

    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule